// File: doc/BRIEF.md
# Audio Automatic Gain Control Engine

This block steers the gain code of one programmable gain stage in an audio record path. Once per audio sample, signalled by a one-clock strobe, it compares a level estimate with a programmed target level. When the level is too loud it lowers the gain, and when it is too quiet it raises the gain. Each step is 0.5 dB, and the pace of the steps is set in sample strobes. A silence detector compares the same level estimate with a noise floor. The detector has a level window (hysteresis) and separate time debounces for entering and leaving silence. While the channel is silent, the gain slides back to 0 dB so that background noise is not amplified.

The level input is an attenuation: how far the signal sits below full scale, in 0.5 dB units, so a larger value means a quieter signal. When the engine is disabled, the gain output follows a manually programmed code. Status outputs report:
- the live silence flag,
- a sticky copy of the silence flag that holds until cleared,
- whether the gain readback is valid,
- a saturation flag for when the engine wants more gain than it is allowed.

Top module: `agc_engine`

## Requirements
- R1: After a synchronous reset, `gain_o` is 0 and `noise_o`, `noise_sticky_o` and `sat_o` are 0.
- R2: While `en_i` is low, `gain_o` takes the value of `manual_gain_i` on every clock. The silence state, the saturation flag and all interval and debounce counters are cleared.
- R3: The effective maximum gain is `max_gain_i`, with codes above 80 treated as 80. On every enabled strobe, the gain is limited to this maximum, so a lowered maximum pulls the gain down at once. The target attenuation for `target_sel_i` codes 0..7 is 11, 16, 20, 24, 28, 34, 40, 48 half-dB (-5.5 dB to -24 dB).
- R4: When the engine is enabled and not silent, and `level_i` is below the target attenuation (louder than target), the gain drops by one step on every (`attack_i`+1)-th consecutive strobe of that direction, and never drops below 0.
- R5: When the engine is enabled and not silent, and `level_i` is above the target attenuation (quieter than target), the gain rises by one step on every (`decay_i`+1)-th consecutive strobe of that direction, and never rises above the effective maximum.
- R6: The gain changes only on strobes while enabled. A strobe whose direction differs from the previous strobe's direction restarts the interval count. A level exactly at target holds the gain and clears the count.
- R7: The noise floor for `noise_thr_i` code k = 1..31 is an attenuation of 60+4(k-1) half-dB (-30 dB to -90 dB); code 0 disables silence detection and clears the silence state on the next strobe. For `hyst_sel_i` codes 0, 1, 2, the window is 2, 4 or 6 half-dB; code 3 means no window. A strobe counts as quiet when the level exceeds floor+window, and as loud when the level is below floor-window.
- R8: Silence is entered on the (`noise_db_i`+1)-th consecutive quiet strobe, and left on the (`signal_db_i`+1)-th consecutive loud strobe. Any strobe that breaks the run restarts the count, so a value of 0 means the change happens on the first such strobe.
- R9: On each strobe that finds the engine already silent, the gain drops by one step toward 0 and then stays at 0.
- R10: On each enabled strobe, `sat_o` is set when the engine was not silent, the level is quieter than target, and the gain before the strobe was already at or above the effective maximum; otherwise `sat_o` is cleared.
- R11: `noise_o` is the live silence state. `noise_sticky_o` is set on the clock after `noise_o` is seen high, and stays set until a clock on which `flag_clr_i` is high and `noise_o` is low. `gain_valid_o` is low while `noise_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Automatic control enable; low selects manual gain |
| strobe_i | input | 1 | One-clock pulse per audio sample |
| level_i | input | 8 | Signal level as attenuation below full scale, 0.5 dB units |
| target_sel_i | input | 3 | Target level select |
| hyst_sel_i | input | 2 | Hysteresis window select |
| noise_thr_i | input | 5 | Noise floor select, 0 disables silence detection |
| max_gain_i | input | 7 | Highest gain allowed, 0.5 dB units |
| attack_i | input | 8 | Strobes per gain decrease, minus one |
| decay_i | input | 8 | Strobes per gain increase, minus one |
| noise_db_i | input | 5 | Quiet strobes needed to enter silence, minus one |
| signal_db_i | input | 4 | Loud strobes needed to leave silence, minus one |
| manual_gain_i | input | 7 | Gain code used while disabled |
| flag_clr_i | input | 1 | Clears the sticky silence flag |
| gain_o | output | 7 | Gain code for the gain stage, 0.5 dB units |
| gain_valid_o | output | 1 | Gain readback is meaningful (not silent) |
| noise_o | output | 1 | Live silence flag |
| noise_sticky_o | output | 1 | Sticky silence flag |
| sat_o | output | 1 | Gain wanted above the allowed maximum |

## Verification
The bench drives strobes whose level alternates between loud and quiet. If a design failed to restart the interval on a direction change, the gain would creep, when it should stay fixed. Runs of quiet strobes are cut one strobe short of the debounce, then made complete. A design that counted total quiet strobes instead of consecutive ones would enter silence too early. Levels inside the hysteresis window must leave the silence state unchanged, so a design that compared with the bare floor would toggle it. Other checks cover a lowered maximum, a maximum code above 80 and a flag clear while silence is live. A wrong design would leave the gain above the limit, pass codes above 80 to the gain stage, or drop the sticky flag while silence persists.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_CUT   = 2'd1,
    DIR_BOOST = 2'd2
  } agc_dir_e;

  // target attenuation in half-dB below full scale
  function automatic logic [8:0] target_att(input logic [2:0] sel);
    case (sel)
      3'd0:    return 9'd11;
      3'd1:    return 9'd16;
      3'd2:    return 9'd20;
      3'd3:    return 9'd24;
      3'd4:    return 9'd28;
      3'd5:    return 9'd34;
      3'd6:    return 9'd40;
      default: return 9'd48;
    endcase
  endfunction

  // noise floor attenuation, code 1..31 -> 60 + 4*(code-1) half-dB
  function automatic logic [8:0] floor_att(input logic [4:0] code);
    logic [4:0] idx;
    idx = code - 5'd1;
    return 9'd60 + {2'b00, idx, 2'b00};
  endfunction

  // hysteresis window in half-dB, code 3 means none
  function automatic logic [8:0] hyst_amt(input logic [1:0] code);
    case (code)
      2'd0:    return 9'd2;
      2'd1:    return 9'd4;
      2'd2:    return 9'd6;
      default: return 9'd0;
    endcase
  endfunction

endpackage

// File: rtl/agc_silence_det.sv
module agc_silence_det #(
  parameter int LVL_W = 8,
  parameter int NDB_W = 5,
  parameter int SDB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [4:0]       thr_code_i,
  input  logic [1:0]       hyst_code_i,
  input  logic [NDB_W-1:0] ndb_i,
  input  logic [SDB_W-1:0] sdb_i,
  output logic             silent_o
);
  import agc_pkg::*;

  localparam int CMP_W = (LVL_W > 9 ? LVL_W : 9) + 1;

  logic [CMP_W-1:0] lvl, flr, win;
  logic             det_on, quiet_now, loud_now;
  logic [NDB_W-1:0] quiet_run;
  logic [SDB_W-1:0] loud_run;

  assign lvl       = CMP_W'(level_i);
  assign flr       = CMP_W'(floor_att(thr_code_i));
  assign win       = CMP_W'(hyst_amt(hyst_code_i));
  assign det_on    = (thr_code_i != 5'd0);
  assign quiet_now = lvl > (flr + win);
  assign loud_now  = (lvl + win) < flr;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      silent_o  <= 1'b0;
      quiet_run <= '0;
      loud_run  <= '0;
    end else if (stb_i) begin
      if (!det_on) begin
        silent_o  <= 1'b0;
        quiet_run <= '0;
        loud_run  <= '0;
      end else if (!silent_o) begin
        loud_run <= '0;
        if (!quiet_now) begin
          quiet_run <= '0;
        end else if (quiet_run >= ndb_i) begin
          silent_o  <= 1'b1;
          quiet_run <= '0;
        end else begin
          quiet_run <= quiet_run + 1'b1;
        end
      end else begin
        quiet_run <= '0;
        if (!loud_now) begin
          loud_run <= '0;
        end else if (loud_run >= sdb_i) begin
          silent_o <= 1'b0;
          loud_run <= '0;
        end else begin
          loud_run <= loud_run + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/agc_gain_ramp.sv
module agc_gain_ramp #(
  parameter int LVL_W  = 8,
  parameter int GAIN_W = 7,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [8:0]        tgt_i,
  input  logic [GAIN_W-1:0] max_i,
  input  logic [TIME_W-1:0] attack_i,
  input  logic [TIME_W-1:0] decay_i,
  input  logic              silent_i,
  input  logic [GAIN_W-1:0] manual_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              sat_o
);
  import agc_pkg::*;

  localparam int CMP_W = (LVL_W > 9 ? LVL_W : 9) + 1;

  agc_dir_e          dir_q, dir_n;
  logic [TIME_W-1:0] run_q, run_eff, period;
  logic              due;
  logic [GAIN_W-1:0] g_step, g_next;
  logic [CMP_W-1:0]  lvl, tgt;

  assign lvl = CMP_W'(level_i);
  assign tgt = CMP_W'(tgt_i);

  always_comb begin
    if (lvl < tgt)      dir_n = DIR_CUT;
    else if (lvl > tgt) dir_n = DIR_BOOST;
    else                dir_n = DIR_HOLD;
    run_eff = (dir_n == dir_q) ? run_q : '0;
    period  = (dir_n == DIR_CUT) ? attack_i : decay_i;
    due     = (dir_n != DIR_HOLD) && (run_eff >= period);
    g_step  = gain_o;
    if (silent_i) begin
      if (gain_o != '0) g_step = gain_o - 1'b1;
    end else if (due && dir_n == DIR_CUT && gain_o != '0) begin
      g_step = gain_o - 1'b1;
    end else if (due && dir_n == DIR_BOOST && gain_o < max_i) begin
      g_step = gain_o + 1'b1;
    end
    g_next = (g_step > max_i) ? max_i : g_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o <= '0;
      sat_o  <= 1'b0;
      dir_q  <= DIR_HOLD;
      run_q  <= '0;
    end else if (!en_i) begin
      gain_o <= manual_i;
      sat_o  <= 1'b0;
      dir_q  <= DIR_HOLD;
      run_q  <= '0;
    end else if (stb_i) begin
      gain_o <= g_next;
      sat_o  <= !silent_i && (dir_n == DIR_BOOST) && (gain_o >= max_i);
      if (silent_i) begin
        dir_q <= DIR_HOLD;
        run_q <= '0;
      end else begin
        dir_q <= dir_n;
        run_q <= (dir_n == DIR_HOLD || due) ? '0 : run_eff + 1'b1;
      end
    end
  end

endmodule

// File: rtl/agc_engine.sv
module agc_engine #(
  parameter int LVL_W    = 8,
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 80,
  parameter int TIME_W   = 8,
  parameter int NDB_W    = 5,
  parameter int SDB_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [2:0]        target_sel_i,
  input  logic [1:0]        hyst_sel_i,
  input  logic [4:0]        noise_thr_i,
  input  logic [GAIN_W-1:0] max_gain_i,
  input  logic [TIME_W-1:0] attack_i,
  input  logic [TIME_W-1:0] decay_i,
  input  logic [NDB_W-1:0]  noise_db_i,
  input  logic [SDB_W-1:0]  signal_db_i,
  input  logic [GAIN_W-1:0] manual_gain_i,
  input  logic              flag_clr_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              gain_valid_o,
  output logic              noise_o,
  output logic              noise_sticky_o,
  output logic              sat_o
);
  import agc_pkg::*;

  localparam logic [GAIN_W-1:0] CAP = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] max_eff;
  logic [8:0]        tgt_att;

  assign max_eff = (max_gain_i > CAP) ? CAP : max_gain_i;
  assign tgt_att = target_att(target_sel_i);

  agc_silence_det #(.LVL_W(LVL_W), .NDB_W(NDB_W), .SDB_W(SDB_W)) u_sil (
    .clk(clk), .rst(rst), .en_i(en_i), .stb_i(strobe_i), .level_i(level_i),
    .thr_code_i(noise_thr_i), .hyst_code_i(hyst_sel_i),
    .ndb_i(noise_db_i), .sdb_i(signal_db_i), .silent_o(noise_o)
  );

  agc_gain_ramp #(.LVL_W(LVL_W), .GAIN_W(GAIN_W), .TIME_W(TIME_W)) u_ramp (
    .clk(clk), .rst(rst), .en_i(en_i), .stb_i(strobe_i), .level_i(level_i),
    .tgt_i(tgt_att), .max_i(max_eff), .attack_i(attack_i), .decay_i(decay_i),
    .silent_i(noise_o), .manual_i(manual_gain_i), .gain_o(gain_o), .sat_o(sat_o)
  );

  always_ff @(posedge clk) begin
    if (rst) noise_sticky_o <= 1'b0;
    else     noise_sticky_o <= noise_o | (noise_sticky_o & ~flag_clr_i);
  end

  assign gain_valid_o = ~noise_o;

endmodule

// File: rtl/agc_engine_chk.sv
module agc_engine_chk #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              strobe_i,
  input logic [4:0]        noise_thr_i,
  input logic [GAIN_W-1:0] max_gain_i,
  input logic [GAIN_W-1:0] manual_gain_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic              noise_o,
  input logic              noise_sticky_o
);
  // R2: disabled engine tracks the manual code
  a_r2_manual_follow: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> gain_o == $past(manual_gain_i));

  // R3: an enabled strobe never leaves gain above the effective maximum
  a_r3_gain_cap: assert property (@(posedge clk) disable iff (rst)
    (en_i && strobe_i) |=> (int'(gain_o) <= int'($past(max_gain_i)))
                           && (int'(gain_o) <= GAIN_MAX));

  // R6: no strobe, no gain change while enabled
  a_r6_strobe_gated: assert property (@(posedge clk) disable iff (rst)
    (en_i && !strobe_i) |=> $stable(gain_o));

  // R6: at most one step up per strobe
  a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
    (en_i && strobe_i) |=> int'(gain_o) <= int'($past(gain_o)) + 1);

  // R9: silent strobe with nonzero gain lowers the gain
  a_r9_walk_down: assert property (@(posedge clk) disable iff (rst)
    (en_i && strobe_i && noise_o && gain_o != '0) |=> gain_o < $past(gain_o));

  // R7: detection disabled clears silence on a strobe
  a_r7_det_off: assert property (@(posedge clk) disable iff (rst)
    (en_i && strobe_i && noise_thr_i == 5'd0) |=> !noise_o);

  // R11: live flag always lands in the sticky flag
  a_r11_sticky_set: assert property (@(posedge clk) disable iff (rst)
    noise_o |=> noise_sticky_o);
endmodule

bind agc_engine agc_engine_chk #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .strobe_i(strobe_i),
  .noise_thr_i(noise_thr_i), .max_gain_i(max_gain_i),
  .manual_gain_i(manual_gain_i), .gain_o(gain_o), .noise_o(noise_o),
  .noise_sticky_o(noise_sticky_o)
);

// File: tb/agc_engine_tb.sv
module agc_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0, strobe_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] level_i = 8'd0, attack_i = 8'd0, decay_i = 8'd0;
  logic [2:0] target_sel_i = 3'd0;
  logic [1:0] hyst_sel_i = 2'd0;
  logic [4:0] noise_thr_i = 5'd0, noise_db_i = 5'd0;
  logic [6:0] max_gain_i = 7'd0, manual_gain_i = 7'd0;
  logic [3:0] signal_db_i = 4'd0;
  logic [6:0] gain_o;
  logic       gain_valid_o, noise_o, noise_sticky_o, sat_o;

  int n_run = 0, n_fail = 0;
  string phase = "R1";

  // reference model state
  int m_gain = 0, m_sil = 0, m_sticky = 0, m_sat = 0, m_dir = 0;
  int m_run = 0, m_qrun = 0, m_lrun = 0;

  always #4 clk = ~clk;

  agc_engine u_dut (.*);

  function automatic int tgt_of(int s);
    int t[8] = '{11, 16, 20, 24, 28, 34, 40, 48};
    return t[s];
  endfunction

  always @(posedge clk) begin
    int old_sil, old_g, tg, mx, fl, hy, lv, d, ce, per;
    old_sil = m_sil; old_g = m_gain;
    if (rst) begin
      m_gain = 0; m_sil = 0; m_sticky = 0; m_sat = 0; m_dir = 0;
      m_run = 0; m_qrun = 0; m_lrun = 0;
    end else begin
      m_sticky = (old_sil != 0 || (m_sticky != 0 && !flag_clr_i)) ? 1 : 0;
      if (!en_i) begin
        m_gain = manual_gain_i; m_sil = 0; m_sat = 0; m_dir = 0;
        m_run = 0; m_qrun = 0; m_lrun = 0;
      end else if (strobe_i) begin
        lv = level_i; tg = tgt_of(target_sel_i);
        mx = (max_gain_i > 80) ? 80 : max_gain_i;
        fl = 60 + 4 * (int'(noise_thr_i) - 1);
        hy = (hyst_sel_i == 3) ? 0 : 2 * (int'(hyst_sel_i) + 1);
        if (noise_thr_i == 0) begin
          m_sil = 0; m_qrun = 0; m_lrun = 0;
        end else if (old_sil == 0) begin
          m_lrun = 0;
          if (lv > fl + hy) begin
            if (m_qrun >= noise_db_i) begin m_sil = 1; m_qrun = 0; end
            else m_qrun++;
          end else m_qrun = 0;
        end else begin
          m_qrun = 0;
          if (lv < fl - hy) begin
            if (m_lrun >= signal_db_i) begin m_sil = 0; m_lrun = 0; end
            else m_lrun++;
          end else m_lrun = 0;
        end
        d = (lv < tg) ? 1 : (lv > tg) ? 2 : 0;
        m_sat = (old_sil == 0 && d == 2 && old_g >= mx) ? 1 : 0;
        if (old_sil != 0) begin
          m_dir = 0; m_run = 0;
          if (m_gain > 0) m_gain--;
        end else begin
          ce = (d == m_dir) ? m_run : 0;
          per = (d == 1) ? attack_i : decay_i;
          if (d == 0) m_run = 0;
          else if (ce >= per) begin
            m_run = 0;
            if (d == 1 && m_gain > 0) m_gain--;
            if (d == 2 && m_gain < mx) m_gain++;
          end else m_run = ce + 1;
          m_dir = d;
        end
        if (m_gain > mx) m_gain = mx;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(phase, gain_o, m_gain);
    chk("R7 noise_o", noise_o, m_sil);
    chk("R11 noise_sticky_o", noise_sticky_o, m_sticky);
    chk("R10 sat_o", sat_o, m_sat);
    chk("R11 gain_valid_o", gain_valid_o, m_sil == 0);
  endtask

  task automatic tick(logic s);
    @(negedge clk);
    compare();
    strobe_i = s;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin tick(1'b1); tick(1'b0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 gain", gain_o, 0);
    chk("R1 flags", {noise_o, noise_sticky_o, sat_o}, 0);

    phase = "R2"; manual_gain_i = 7'd25;
    tick(0); tick(0);
    chk("R2 manual", gain_o, 25);
    manual_gain_i = 7'd33; tick(1); tick(0);
    chk("R2 manual ignores strobe", gain_o, 33);

    phase = "R3"; en_i = 1'b1; max_gain_i = 7'd10; level_i = 8'd100;
    decay_i = 8'd2; target_sel_i = 3'd0;
    strobes(1);
    chk("R3 clamp to lowered max", gain_o, 10);
    phase = "R10"; strobes(3);
    chk("R10 sat at max", sat_o, 1);
    phase = "R5"; max_gain_i = 7'd100; decay_i = 8'd0;
    strobes(100);
    chk("R3 max code above 80 caps at 80", gain_o, 80);
    max_gain_i = 7'd40; strobes(2);
    chk("R3 lowered max pulls gain down", gain_o, 40);

    phase = "R4"; level_i = 8'd5; attack_i = 8'd3; strobes(30);
    phase = "R6"; level_i = 8'd11; strobes(1);
    for (int i = 0; i < 5; i++) strobes(1);
    chk("R6 hold at target", gain_o, m_gain);
    attack_i = 8'd1; decay_i = 8'd1;
    begin
      int g0;
      g0 = gain_o;
      for (int i = 0; i < 20; i++) begin
        level_i = (i % 2 == 0) ? 8'd5 : 8'd100;
        strobes(1);
      end
      chk("R6 alternating directions restart interval", gain_o, g0);
      level_i = 8'd5;
      for (int i = 0; i < 12; i++) begin tick(0); level_i = (i % 2) ? 8'd5 : 8'd200; end
      chk("R6 no strobe no change", gain_o, g0);
    end
    phase = "R4"; level_i = 8'd5; attack_i = 8'd0; strobes(90);
    chk("R4 floor at 0", gain_o, 0);

    phase = "R5"; level_i = 8'd100; decay_i = 8'd0; strobes(20);
    chk("R5 ramp up", gain_o, 20);

    phase = "R8"; noise_thr_i = 5'd1; hyst_sel_i = 2'd0; noise_db_i = 5'd3;
    signal_db_i = 4'd2; level_i = 8'd70; strobes(3);
    level_i = 8'd61; strobes(1);
    chk("R8 broken quiet run", noise_o, 0);
    level_i = 8'd70; strobes(3);
    chk("R8 three quiet strobes not enough", noise_o, 0);
    strobes(1);
    chk("R8 fourth quiet strobe enters", noise_o, 1);

    phase = "R9"; strobes(40);
    chk("R9 walked to zero", gain_o, 0);
    chk("R11 sticky set", noise_sticky_o, 1);
    chk("R11 valid low", gain_valid_o, 0);
    flag_clr_i = 1'b1; tick(0); flag_clr_i = 1'b0; tick(0);
    chk("R11 clear while live keeps sticky", noise_sticky_o, 1);

    phase = "R7"; level_i = 8'd59; strobes(5);
    chk("R7 inside window stays silent", noise_o, 1);
    phase = "R8"; level_i = 8'd57; strobes(2);
    chk("R8 two loud strobes not enough", noise_o, 1);
    strobes(1);
    chk("R8 third loud strobe leaves", noise_o, 0);

    phase = "R7"; hyst_sel_i = 2'd3; noise_db_i = 5'd0; signal_db_i = 4'd0;
    level_i = 8'd61; strobes(1);
    chk("R7 no window enters at floor+1", noise_o, 1);
    level_i = 8'd59; strobes(1);
    chk("R7 no window leaves at floor-1", noise_o, 0);
    level_i = 8'd120; strobes(1);
    noise_thr_i = 5'd0; strobes(1);
    chk("R7 code 0 disables detection", noise_o, 0);
    noise_thr_i = 5'd31; level_i = 8'd185; strobes(1);
    chk("R7 code 31 floor 180", noise_o, 1);

    phase = "R11"; noise_thr_i = 5'd0; strobes(1);
    chk("R11 sticky holds after live drops", noise_sticky_o, 1);
    flag_clr_i = 1'b1; tick(0); flag_clr_i = 1'b0; tick(0);
    chk("R11 clear drops sticky", noise_sticky_o, 0);

    phase = "R2"; noise_thr_i = 5'd1; level_i = 8'd120; strobes(2);
    manual_gain_i = 7'd7; en_i = 1'b0; tick(0); tick(0);
    chk("R2 disable clears silence", noise_o, 0);
    chk("R2 disable gain manual", gain_o, 7);

    tick(0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule